// File: doc/BRIEF.md
# Calendar-Driven Transmit Port Scheduler

This block decides which transmit port the outgoing link serves next. A programmable calendar lists, slot by slot, a port number, a user-assigned identifier, a buffer partition and a burst length. The scheduler walks the calendar in a ring. For each slot it looks up the port's two-bit flow status. It then spends the burst issuing one 128-bit line read per cycle to that partition and forwards each returned line onto the link stream.

While a slot is in service, the block shows the serviced port (its real number or its user identifier), that port's flow status and the programmed burst length. A link-disable input freezes the schedule at once. No reads are issued and the link side sees idle cycles until the input drops. Service then resumes where it stopped, and the upstream writers keep filling the partitions in the meantime.

The partition buffer answers a read request in the same cycle. It raises `line_vld` together with the line and its end-of-packet flag when the partition holds a line, and that line counts as consumed at the clock edge.

Top module: `tx_cal_sched`

## Requirements
- R1: While `rst_n` is low, at the next clock edge `rd_req`, `tx_vld`, `tx_eop` and `svc_active` go to 0 and `tx_idle` goes to 1. Every calendar entry returns to port 0, user ID 0, partition 0 and burst code 0. Every port status returns to 2'b00, and the walk restarts at entry 0.
- R2: Entries are served in ascending index order. After entry `cfg_cal_len`-1 the walk wraps to entry 0. A `cfg_cal_len` of 0, or a value above the calendar depth, means that every entry is used.
- R3: A served entry with burst code N (1 to 15) gets exactly N cycles with `rd_req` high, each aimed at the entry's partition on `rd_part`, and burst code 0 means 16 cycles. Each entry is selected in one cycle with `rd_req` low, which comes before its burst.
- R4: During a burst `svc_active` is 1. `svc_port_id` carries the entry's user ID when `cfg_use_uid` is 1 and its port number when it is 0. `svc_burst` carries the programmed burst code, and `svc_stat` carries the port's status as it was at selection. `svc_active` is 0 in selection cycles.
- R5: A burst cycle in which the partition is empty (`line_vld` low) still uses up one cycle of the burst. It yields an idle cycle on the link side.
- R6: A line returned with `line_eop` high ends the burst after that cycle, and the next entry is selected.
- R7: An entry whose port status is 2'b11 (stop) is passed over in its selection cycle with no read issued. The walk moves on to the next entry.
- R8: While `link_dis` is 1, `rd_req` is 0. The calendar position and the remaining burst count are held. When `link_dis` returns to 0, the interrupted burst finishes its remaining cycles.
- R9: A line accepted in a cycle (`rd_req` and `line_vld` both high) appears on `tx_data` in the next cycle with `tx_vld` 1 and with `tx_eop` copied from `line_eop`. In every other cycle `tx_idle` is 1 and `tx_vld` is 0.
- R10: Port status is written through `stat_wr_en`/`stat_wr_port`/`stat_wr_val` for ports 0 to STAT_DEPTH-1. A port number outside that range reads status 2'b00, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_cal_len | input | LEN_W | Number of calendar entries in use (0 = all) |
| cfg_use_uid | input | 1 | 1 shows the user ID on `svc_port_id`, 0 shows the port number |
| cal_wr_en | input | 1 | Calendar entry write strobe |
| cal_wr_idx | input | IDX_W | Calendar entry being written |
| cal_wr_port | input | PORT_W | Port number for the entry |
| cal_wr_uid | input | PORT_W | User ID for the entry |
| cal_wr_part | input | PART_W | Buffer partition for the entry |
| cal_wr_burst | input | BURST_W | Burst code for the entry (0 = 16) |
| stat_wr_en | input | 1 | Port status write strobe |
| stat_wr_port | input | PORT_W | Port whose status is written |
| stat_wr_val | input | 2 | New status; 2'b11 means stop |
| link_dis | input | 1 | Freeze the schedule and send idle |
| rd_req | output | 1 | Line read request to the partition buffer |
| rd_part | output | PART_W | Partition being read |
| line_vld | input | 1 | A line is returned this cycle |
| line_data | input | LINE_W | Returned line |
| line_eop | input | 1 | Returned line ends a packet |
| tx_vld | output | 1 | `tx_data` holds a line |
| tx_idle | output | 1 | Idle cycle on the link side |
| tx_data | output | LINE_W | Line towards the link |
| tx_eop | output | 1 | Line on `tx_data` ends a packet |
| svc_active | output | 1 | A burst is in service |
| svc_port_id | output | PORT_W | Serviced port number or user ID |
| svc_stat | output | 2 | Status of the serviced port |
| svc_burst | output | BURST_W | Burst code of the serviced entry |

## Verification
The bench builds the scheduler with a 4-entry calendar, an 8-port status table and 32-bit lines. The short calendar lets a length of 0 reach the full-depth wrap within about a dozen cycles. The small lines leave room to tag each one with its partition and sequence number. A partition model with per-partition line limits and a chosen end-of-packet position makes empty-partition, early-stop and freeze cases land on cycles the bench can name.

// File: rtl/tx_sched_pkg.sv
// Shared definitions for the calendar transmit scheduler.
// Assumes: nothing beyond a 1800-2017 compiler.
package tx_sched_pkg;

    // Scheduler phases: choose a calendar entry, or serve its burst.
    typedef enum logic {
        SEL_ST = 1'b0,
        SRV_ST = 1'b1
    } sched_state_e;

    localparam int          FLOW_W    = 2;
    // Flow status value that forbids service of a port.
    localparam logic [1:0]  FLOW_STOP = 2'b11;

endpackage

// File: rtl/tx_cal_table.sv
// Calendar storage: DEPTH entries of {port, user ID, partition, burst code}.
// One write port and one asynchronous read port.
// Assumes: wr_idx and rd_idx stay below DEPTH; reset is synchronous, active low.
module tx_cal_table #(
    parameter int DEPTH   = 16,
    parameter int IDX_W   = 4,
    parameter int PORT_W  = 8,
    parameter int PART_W  = 3,
    parameter int BURST_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [PORT_W-1:0]  wr_port,
    input  logic [PORT_W-1:0]  wr_uid,
    input  logic [PART_W-1:0]  wr_part,
    input  logic [BURST_W-1:0] wr_burst,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [PORT_W-1:0]  rd_port,
    output logic [PORT_W-1:0]  rd_uid,
    output logic [PART_W-1:0]  rd_part,
    output logic [BURST_W-1:0] rd_burst
);

    logic [PORT_W-1:0]  port_q  [DEPTH];
    logic [PORT_W-1:0]  uid_q   [DEPTH];
    logic [PART_W-1:0]  part_q  [DEPTH];
    logic [BURST_W-1:0] burst_q [DEPTH];

    // Clear every entry on reset; update the addressed entry on a write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                port_q[i]  <= '0;
                uid_q[i]   <= '0;
                part_q[i]  <= '0;
                burst_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                port_q[i]  <= wr_port;
                uid_q[i]   <= wr_uid;
                part_q[i]  <= wr_part;
                burst_q[i] <= wr_burst;
            end
        end
    end

    // Present the entry the scheduler is looking at.
    always_comb begin
        rd_port  = port_q[rd_idx];
        rd_uid   = uid_q[rd_idx];
        rd_part  = part_q[rd_idx];
        rd_burst = burst_q[rd_idx];
    end

endmodule

// File: rtl/tx_flow_table.sv
// Per-port flow status store, one 2-bit entry per port 0..DEPTH-1.
// Ports at or above DEPTH read as status 0 and their writes are dropped.
// Assumes: DEPTH <= 2**PORT_W; reset is synchronous, active low.
module tx_flow_table
    import tx_sched_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_port,
    input  logic [FLOW_W-1:0] wr_val,
    input  logic [PORT_W-1:0] rd_port,
    output logic [FLOW_W-1:0] rd_val
);

    logic [DEPTH-1:0][FLOW_W-1:0] hit_val;

    for (genvar g = 0; g < DEPTH; g++) begin : g_port
        logic [FLOW_W-1:0] val_q;

        // Hold the status of port g; reset to 0, overwrite on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (wr_en && (wr_port == PORT_W'(g))) begin
                val_q <= wr_val;
            end
        end

        // Offer the status only when port g is the one being looked up.
        assign hit_val[g] = (rd_port == PORT_W'(g)) ? val_q : '0;
    end

    // Combine the per-port offers; at most one is non-zero.
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < DEPTH; i++) begin
            rd_val = rd_val | hit_val[i];
        end
    end

endmodule

// File: rtl/tx_sched_fsm.sv
// Calendar walker and burst engine. Selects one entry per selection cycle,
// skips ports in stop state, then issues one read per burst cycle until the
// burst count runs out or an end-of-packet line comes back. link_dis holds
// every piece of state and blocks reads.
// Assumes: the buffer answers rd_req in the same cycle; line_vld is only
// meaningful while rd_req is high; reset is synchronous, active low.
module tx_sched_fsm
    import tx_sched_pkg::*;
#(
    parameter int CAL_DEPTH = 16,
    parameter int IDX_W     = 4,
    parameter int LEN_W     = 5,
    parameter int PORT_W    = 8,
    parameter int PART_W    = 3,
    parameter int BURST_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               link_dis,
    input  logic [LEN_W-1:0]   cfg_cal_len,
    input  logic               cfg_use_uid,
    input  logic [PORT_W-1:0]  ent_port,
    input  logic [PORT_W-1:0]  ent_uid,
    input  logic [PART_W-1:0]  ent_part,
    input  logic [BURST_W-1:0] ent_burst,
    input  logic [FLOW_W-1:0]  ent_stat,
    input  logic               line_vld,
    input  logic               line_eop,
    output logic [IDX_W-1:0]   cal_idx,
    output logic               rd_req,
    output logic [PART_W-1:0]  rd_part,
    output logic               svc_active,
    output logic [PORT_W-1:0]  svc_port_id,
    output logic [FLOW_W-1:0]  svc_stat,
    output logic [BURST_W-1:0] svc_burst
);

    localparam int                CNT_W      = BURST_W + 1;
    localparam logic [LEN_W-1:0]  DEPTH_L    = LEN_W'(CAL_DEPTH);
    localparam logic [IDX_W-1:0]  LAST_FULL  = IDX_W'(CAL_DEPTH - 1);
    localparam logic [CNT_W-1:0]  FULL_BURST = CNT_W'(2 ** BURST_W);

    sched_state_e       st_q;
    logic [IDX_W-1:0]   idx_q;
    logic [IDX_W-1:0]   last_idx;
    logic [IDX_W-1:0]   next_idx;
    logic [CNT_W-1:0]   cnt_q;
    logic [PART_W-1:0]  part_q;
    logic               burst_end;

    // Last calendar index in use; 0 or an oversize length means the whole table.
    always_comb begin
        if ((cfg_cal_len == '0) || (cfg_cal_len > DEPTH_L)) begin
            last_idx = LAST_FULL;
        end else begin
            last_idx = IDX_W'(cfg_cal_len - 1'b1);
        end
    end

    // Ring successor of the current calendar position.
    assign next_idx  = (idx_q >= last_idx) ? '0 : idx_q + 1'b1;

    // A burst closes on its last counted cycle or on an end-of-packet line.
    assign burst_end = (line_vld && line_eop) || (cnt_q == CNT_W'(1));

    assign rd_req     = (st_q == SRV_ST) && !link_dis;
    assign rd_part    = part_q;
    assign cal_idx    = idx_q;
    assign svc_active = (st_q == SRV_ST);

    // Walk the calendar and run bursts; everything holds while link_dis is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= SEL_ST;
            idx_q       <= '0;
            cnt_q       <= '0;
            part_q      <= '0;
            svc_port_id <= '0;
            svc_stat    <= '0;
            svc_burst   <= '0;
        end else if (!link_dis) begin
            case (st_q)
                SEL_ST: begin
                    if (ent_stat == FLOW_STOP) begin
                        idx_q <= next_idx;
                    end else begin
                        st_q        <= SRV_ST;
                        cnt_q       <= (ent_burst == '0) ? FULL_BURST : CNT_W'(ent_burst);
                        part_q      <= ent_part;
                        svc_port_id <= cfg_use_uid ? ent_uid : ent_port;
                        svc_stat    <= ent_stat;
                        svc_burst   <= ent_burst;
                    end
                end
                SRV_ST: begin
                    if (burst_end) begin
                        st_q  <= SEL_ST;
                        idx_q <= next_idx;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: st_q <= SEL_ST;
            endcase
        end
    end

    AST_READ_HAS_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (cnt_q != '0)); // R3
    AST_NO_STOP_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        svc_active |-> (svc_stat != FLOW_STOP)); // R7
    AST_EOP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && line_vld && line_eop) |=> !svc_active); // R6
    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        link_dis |=> ($stable(cnt_q) && $stable(idx_q) && $stable(st_q))); // R8
    AST_IDX_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idx_q) < CAL_DEPTH)); // R2

endmodule

// File: rtl/tx_line_out.sv
// Link-side output register: forwards an accepted line one cycle later,
// otherwise marks the cycle idle.
// Assumes: a line is accepted when take_req and line_vld are both high;
// reset is synchronous, active low.
module tx_line_out #(
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_req,
    input  logic              line_vld,
    input  logic [LINE_W-1:0] line_data,
    input  logic              line_eop,
    output logic              tx_vld,
    output logic              tx_idle,
    output logic [LINE_W-1:0] tx_data,
    output logic              tx_eop
);

    logic accept;

    assign accept = take_req && line_vld;

    // Register the accepted line, or an idle marker when nothing was taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_vld  <= 1'b0;
            tx_idle <= 1'b1;
            tx_data <= '0;
            tx_eop  <= 1'b0;
        end else begin
            tx_vld  <= accept;
            tx_idle <= !accept;
            tx_data <= accept ? line_data : '0;
            tx_eop  <= accept && line_eop;
        end
    end

    AST_LINE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (tx_vld && !tx_idle && (tx_data == $past(line_data)))); // R9
    AST_EMPTY_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && !line_vld) |=> (tx_idle && !tx_vld)); // R5

endmodule

// File: rtl/tx_cal_sched.sv
// Calendar-driven transmit scheduler top. Joins the calendar store, the
// per-port status store, the walker/burst engine and the link-side register.
// Assumes: CAL_DEPTH >= 2 and STAT_DEPTH <= 2**PORT_W; one clock domain;
// synchronous active-low reset.
module tx_cal_sched
    import tx_sched_pkg::*;
#(
    parameter int CAL_DEPTH  = 16,
    parameter int STAT_DEPTH = 16,
    parameter int PORT_W     = 8,
    parameter int PART_W     = 3,
    parameter int BURST_W    = 4,
    parameter int LINE_W     = 128,
    localparam int IDX_W     = $clog2(CAL_DEPTH),
    localparam int LEN_W     = $clog2(CAL_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEN_W-1:0]   cfg_cal_len,
    input  logic               cfg_use_uid,
    input  logic               cal_wr_en,
    input  logic [IDX_W-1:0]   cal_wr_idx,
    input  logic [PORT_W-1:0]  cal_wr_port,
    input  logic [PORT_W-1:0]  cal_wr_uid,
    input  logic [PART_W-1:0]  cal_wr_part,
    input  logic [BURST_W-1:0] cal_wr_burst,
    input  logic               stat_wr_en,
    input  logic [PORT_W-1:0]  stat_wr_port,
    input  logic [1:0]         stat_wr_val,
    input  logic               link_dis,
    output logic               rd_req,
    output logic [PART_W-1:0]  rd_part,
    input  logic               line_vld,
    input  logic [LINE_W-1:0]  line_data,
    input  logic               line_eop,
    output logic               tx_vld,
    output logic               tx_idle,
    output logic [LINE_W-1:0]  tx_data,
    output logic               tx_eop,
    output logic               svc_active,
    output logic [PORT_W-1:0]  svc_port_id,
    output logic [1:0]         svc_stat,
    output logic [BURST_W-1:0] svc_burst
);

    logic [IDX_W-1:0]   cal_idx;
    logic [PORT_W-1:0]  ent_port;
    logic [PORT_W-1:0]  ent_uid;
    logic [PART_W-1:0]  ent_part;
    logic [BURST_W-1:0] ent_burst;
    logic [FLOW_W-1:0]  ent_stat;

    tx_cal_table #(
        .DEPTH   (CAL_DEPTH),
        .IDX_W   (IDX_W),
        .PORT_W  (PORT_W),
        .PART_W  (PART_W),
        .BURST_W (BURST_W)
    ) u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cal_wr_en),
        .wr_idx   (cal_wr_idx),
        .wr_port  (cal_wr_port),
        .wr_uid   (cal_wr_uid),
        .wr_part  (cal_wr_part),
        .wr_burst (cal_wr_burst),
        .rd_idx   (cal_idx),
        .rd_port  (ent_port),
        .rd_uid   (ent_uid),
        .rd_part  (ent_part),
        .rd_burst (ent_burst)
    );

    tx_flow_table #(
        .DEPTH  (STAT_DEPTH),
        .PORT_W (PORT_W)
    ) u_flow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (stat_wr_en),
        .wr_port (stat_wr_port),
        .wr_val  (stat_wr_val),
        .rd_port (ent_port),
        .rd_val  (ent_stat)
    );

    tx_sched_fsm #(
        .CAL_DEPTH (CAL_DEPTH),
        .IDX_W     (IDX_W),
        .LEN_W     (LEN_W),
        .PORT_W    (PORT_W),
        .PART_W    (PART_W),
        .BURST_W   (BURST_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_dis    (link_dis),
        .cfg_cal_len (cfg_cal_len),
        .cfg_use_uid (cfg_use_uid),
        .ent_port    (ent_port),
        .ent_uid     (ent_uid),
        .ent_part    (ent_part),
        .ent_burst   (ent_burst),
        .ent_stat    (ent_stat),
        .line_vld    (line_vld),
        .line_eop    (line_eop),
        .cal_idx     (cal_idx),
        .rd_req      (rd_req),
        .rd_part     (rd_part),
        .svc_active  (svc_active),
        .svc_port_id (svc_port_id),
        .svc_stat    (svc_stat),
        .svc_burst   (svc_burst)
    );

    tx_line_out #(
        .LINE_W (LINE_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_req  (rd_req),
        .line_vld  (line_vld),
        .line_data (line_data),
        .line_eop  (line_eop),
        .tx_vld    (tx_vld),
        .tx_idle   (tx_idle),
        .tx_data   (tx_data),
        .tx_eop    (tx_eop)
    );

    AST_DISABLED_NO_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (link_dis && $past(link_dis)) |-> (!rd_req && !tx_vld)); // R8

endmodule

// File: tb/tx_cal_sched_tb.sv
// Directed bench for tx_cal_sched: one task per scenario, each checking itself.
module tx_cal_sched_tb;

    localparam int CAL_DEPTH  = 4;
    localparam int STAT_DEPTH = 8;
    localparam int PORT_W     = 8;
    localparam int PART_W     = 3;
    localparam int BURST_W    = 4;
    localparam int LINE_W     = 32;
    localparam int IDX_W      = 2;
    localparam int LEN_W      = 3;
    localparam int NPART      = 8;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [LEN_W-1:0]   cfg_cal_len;
    logic               cfg_use_uid;
    logic               cal_wr_en;
    logic [IDX_W-1:0]   cal_wr_idx;
    logic [PORT_W-1:0]  cal_wr_port;
    logic [PORT_W-1:0]  cal_wr_uid;
    logic [PART_W-1:0]  cal_wr_part;
    logic [BURST_W-1:0] cal_wr_burst;
    logic               stat_wr_en;
    logic [PORT_W-1:0]  stat_wr_port;
    logic [1:0]         stat_wr_val;
    logic               link_dis;
    logic               rd_req;
    logic [PART_W-1:0]  rd_part;
    logic               line_vld;
    logic [LINE_W-1:0]  line_data;
    logic               line_eop;
    logic               tx_vld;
    logic               tx_idle;
    logic [LINE_W-1:0]  tx_data;
    logic               tx_eop;
    logic               svc_active;
    logic [PORT_W-1:0]  svc_port_id;
    logic [1:0]         svc_stat;
    logic [BURST_W-1:0] svc_burst;

    tx_cal_sched #(
        .CAL_DEPTH  (CAL_DEPTH),
        .STAT_DEPTH (STAT_DEPTH),
        .PORT_W     (PORT_W),
        .PART_W     (PART_W),
        .BURST_W    (BURST_W),
        .LINE_W     (LINE_W)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .cfg_cal_len (cfg_cal_len), .cfg_use_uid (cfg_use_uid),
        .cal_wr_en (cal_wr_en), .cal_wr_idx (cal_wr_idx),
        .cal_wr_port (cal_wr_port), .cal_wr_uid (cal_wr_uid),
        .cal_wr_part (cal_wr_part), .cal_wr_burst (cal_wr_burst),
        .stat_wr_en (stat_wr_en), .stat_wr_port (stat_wr_port),
        .stat_wr_val (stat_wr_val), .link_dis (link_dis),
        .rd_req (rd_req), .rd_part (rd_part),
        .line_vld (line_vld), .line_data (line_data), .line_eop (line_eop),
        .tx_vld (tx_vld), .tx_idle (tx_idle), .tx_data (tx_data), .tx_eop (tx_eop),
        .svc_active (svc_active), .svc_port_id (svc_port_id),
        .svc_stat (svc_stat), .svc_burst (svc_burst)
    );

    always #2.5 clk = ~clk;

    // Partition model: limit and eop position set by tasks, consumption by the clock.
    int limit  [NPART];
    int eop_at [NPART];
    int cons   [NPART];

    always_comb begin
        line_vld  = rd_req && (cons[rd_part] < limit[rd_part]);
        line_data = {8'(rd_part), 24'(cons[rd_part])};
        line_eop  = line_vld && (cons[rd_part] == eop_at[rd_part]);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPART; p++) cons[p] <= 0;
        end else if (rd_req && line_vld) begin
            cons[rd_part] <= cons[rd_part] + 1;
        end
    end

    // Monitor, sampled at the falling edge.
    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;
    bit  mon_en = 1'b0;
    int  n_req, n_rd, n_out, n_eop;
    int  rd_log [64];

    always @(negedge clk) begin
        if (mon_en) begin
            if (rd_req) n_req++;
            if (rd_req && line_vld) begin
                if (n_rd < 64) rd_log[n_rd] = int'(rd_part);
                n_rd++;
            end
            if (tx_vld) n_out++;
            if (tx_eop) n_eop++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_req = 0; n_rd = 0; n_out = 0; n_eop = 0;
        for (int i = 0; i < 64; i++) rd_log[i] = -1;
    endtask

    task automatic do_reset();
        mon_en = 1'b0;
        rst_n = 1'b0; link_dis = 1'b1;
        cfg_cal_len = '0; cfg_use_uid = 1'b0;
        cal_wr_en = 1'b0; cal_wr_idx = '0; cal_wr_port = '0; cal_wr_uid = '0;
        cal_wr_part = '0; cal_wr_burst = '0;
        stat_wr_en = 1'b0; stat_wr_port = '0; stat_wr_val = '0;
        for (int p = 0; p < NPART; p++) begin
            limit[p] = 0; eop_at[p] = -1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put_ent(input int idx, input int port, input int uid,
                           input int part, input int burst);
        @(negedge clk);
        cal_wr_en = 1'b1; cal_wr_idx = IDX_W'(idx);
        cal_wr_port = PORT_W'(port); cal_wr_uid = PORT_W'(uid);
        cal_wr_part = PART_W'(part); cal_wr_burst = BURST_W'(burst);
        @(negedge clk);
        cal_wr_en = 1'b0;
    endtask

    task automatic put_stat(input int port, input int val);
        @(negedge clk);
        stat_wr_en = 1'b1; stat_wr_port = PORT_W'(port); stat_wr_val = 2'(val);
        @(negedge clk);
        stat_wr_en = 1'b0;
    endtask

    task automatic start();
        clear_mon();
        @(negedge clk);
        #1;
        link_dis = 1'b0;
        mon_en = 1'b1;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // R1: reset values, then default entry (port 0, partition 0, code 0 = 16 cycles).
    task automatic t_reset();
        rst_n = 1'b0; link_dis = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 rd_req in reset", int'(rd_req), 0);
        chk("R1 tx_vld in reset", int'(tx_vld), 0);
        chk("R1 tx_idle in reset", int'(tx_idle), 1);
        chk("R1 svc_active in reset", int'(svc_active), 0);
        do_reset();
        cfg_cal_len = LEN_W'(1);
        limit[0] = 100;
        start();
        run(1);
        chk("R1 default entry port", int'(svc_port_id), 0);
        chk("R1 default entry burst code", int'(svc_burst), 0);
        chk("R1 default status", int'(svc_stat), 0);
        run(16);
        chk("R3 burst code 0 gives 16 reads", n_rd, 16);
        chk("R3 selection cycle after 16", int'(svc_active), 0);
        mon_en = 1'b0;
    endtask

    // R2/R3/R4/R9: three-entry ring, two rounds.
    task automatic t_order();
        int exp_seq [12] = '{0, 0, 1, 1, 1, 2, 0, 0, 1, 1, 1, 2};
        int seq_err = 0;
        do_reset();
        put_stat(1, 1); put_stat(2, 2);
        put_ent(0, 1, 8'h31, 0, 2);
        put_ent(1, 2, 8'h32, 1, 3);
        put_ent(2, 3, 8'h33, 2, 1);
        put_ent(3, 4, 8'h34, 3, 1);
        cfg_cal_len = LEN_W'(3);
        limit[0] = 100; limit[1] = 100; limit[2] = 100; limit[3] = 100;
        start();
        run(1);
        chk("R4 svc_port_id real port", int'(svc_port_id), 1);
        chk("R4 svc_burst", int'(svc_burst), 2);
        chk("R4 svc_stat", int'(svc_stat), 1);
        chk("R4 svc_active in burst", int'(svc_active), 1);
        run(2);
        chk("R3 selection gap between entries", int'(svc_active), 0);
        run(15);
        chk("R3 reads in two rounds", n_rd, 12);
        chk("R9 lines forwarded", n_out, 12);
        for (int i = 0; i < 12; i++) if (rd_log[i] != exp_seq[i]) seq_err++;
        chk("R2 partition order over wrap", seq_err, 0);
        mon_en = 1'b0;
    endtask

    // R4: user ID shown when selected.
    task automatic t_uid();
        do_reset();
        put_ent(0, 5, 8'hA5, 1, 1);
        cfg_cal_len = LEN_W'(1);
        cfg_use_uid = 1'b1;
        limit[1] = 10;
        start();
        run(1);
        chk("R4 svc_port_id user ID", int'(svc_port_id), 8'hA5);
        mon_en = 1'b0;
    endtask

    // R5: empty partition burns burst cycles as idle.
    task automatic t_empty();
        do_reset();
        put_ent(0, 1, 0, 3, 3);
        put_ent(1, 2, 0, 0, 1);
        cfg_cal_len = LEN_W'(2);
        limit[0] = 100;
        start();
        run(6);
        chk("R5 requests incl. empty cycles", n_req, 4);
        chk("R5 lines actually read", n_rd, 1);
        chk("R5 next entry read partition", rd_log[0], 0);
        chk("R5 only one line forwarded", n_out, 1);
        mon_en = 1'b0;
    endtask

    // R6: end-of-packet cuts a 5-cycle burst after its second line.
    task automatic t_eop();
        do_reset();
        put_ent(0, 1, 0, 0, 5);
        put_ent(1, 2, 0, 1, 1);
        cfg_cal_len = LEN_W'(2);
        limit[0] = 100; limit[1] = 100; eop_at[0] = 1;
        start();
        run(4);
        chk("R6 reads before next entry", n_rd, 3);
        chk("R6 third read goes to next partition", rd_log[2], 1);
        chk("R9 eop forwarded once", n_eop, 1);
        mon_en = 1'b0;
    endtask

    // R7: entry whose port is in stop state is passed over.
    task automatic t_skip();
        int exp_seq [4] = '{1, 2, 2, 1};
        int seq_err = 0;
        do_reset();
        put_stat(1, 3); put_stat(2, 1);
        put_ent(0, 1, 0, 0, 1);
        put_ent(1, 2, 0, 1, 1);
        put_ent(2, 3, 0, 2, 2);
        cfg_cal_len = LEN_W'(3);
        limit[0] = 100; limit[1] = 100; limit[2] = 100;
        start();
        run(8);
        chk("R7 reads with one entry skipped", n_rd, 4);
        for (int i = 0; i < 4; i++) if (rd_log[i] != exp_seq[i]) seq_err++;
        chk("R7 stopped partition never read", seq_err, 0);
        mon_en = 1'b0;
    endtask

    // R8: link disable mid-burst freezes, then the burst resumes.
    task automatic t_freeze();
        do_reset();
        put_ent(0, 0, 0, 0, 4);
        cfg_cal_len = LEN_W'(1);
        limit[0] = 100;
        start();
        run(2);
        chk("R8 reads before disable", n_rd, 2);
        @(posedge clk);
        #1;
        link_dis = 1'b1;
        clear_mon();
        run(5);
        chk("R8 no requests while disabled", n_req, 0);
        chk("R8 only in-flight line forwarded", n_out, 1);
        chk("R8 idle while disabled", int'(tx_idle), 1);
        chk("R8 burst held while disabled", int'(svc_active), 1);
        @(posedge clk);
        #1;
        link_dis = 1'b0;
        clear_mon();
        run(7);
        chk("R8 remaining 2 reads then next burst of 4", n_rd, 6);
        mon_en = 1'b0;
    endtask

    // R2: length 0 uses all four entries.
    task automatic t_wrap();
        int exp_seq [7] = '{0, 0, 0, 1, 2, 3, 0};
        int seq_err = 0;
        do_reset();
        put_ent(0, 0, 0, 0, 3);
        put_ent(1, 1, 0, 1, 1);
        put_ent(2, 2, 0, 2, 1);
        put_ent(3, 3, 0, 3, 1);
        cfg_cal_len = '0;
        for (int p = 0; p < 4; p++) limit[p] = 100;
        start();
        run(11);
        chk("R2 reads over full-depth ring", n_rd, 7);
        for (int i = 0; i < 7; i++) if (rd_log[i] != exp_seq[i]) seq_err++;
        chk("R2 full-depth order", seq_err, 0);
        mon_en = 1'b0;
    endtask

    // R10: status writes beyond STAT_DEPTH are dropped and read as 0.
    task automatic t_stat_range();
        do_reset();
        put_stat(9, 3);
        put_stat(1, 3);
        put_ent(0, 9, 0, 0, 1);
        put_ent(1, 1, 0, 1, 1);
        cfg_cal_len = LEN_W'(2);
        limit[0] = 100; limit[1] = 100;
        start();
        run(1);
        chk("R10 out-of-range port served", int'(svc_active), 1);
        chk("R10 out-of-range port status", int'(svc_stat), 0);
        run(3);
        chk("R10 in-range stopped port never read", n_rd, 2);
        mon_en = 1'b0;
    endtask

    initial begin
        do_reset();
        t_reset();
        t_order();
        t_uid();
        t_empty();
        t_eop();
        t_skip();
        t_freeze();
        t_wrap();
        t_stat_range();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule